// File: doc/BRIEF.md
# Single-Channel Data Mover

This block is one channel of a direct memory access engine. It copies a run of data units from a source address to a destination address over a simple bus master port. The source and destination come from one of three routes: peripheral to memory, memory to peripheral, or memory to memory. The software-visible configuration appears as plain input pins. These pins set the route, the unit size (one or two bytes), whether the memory pointer counts up or down, one-shot or circular operation, two interrupt enables, the number of units, and the two base addresses.

In the two peripheral routes, each pulse on the request input moves exactly one unit. In the memory-to-memory route, the channel moves units back to back with no request. An 8-bit down-counter holds the number of remaining units and can be read at all times. A half-way flag and a completion flag record progress, and each flag drives the interrupt only when its own enable is set. The channel does not arbitrate between channels. It holds its bus request until the bus grants it, and it treats a granted cycle as a complete single-cycle read or write.

Top module: `dma_chan_engine`

## Requirements
- R1: `dir` selects the route. `0` means the source is the peripheral address and the destination is the memory pointer. `1` means the source is the memory pointer and the destination is the peripheral address. When `dir[1]` is `1`, the source is the memory pointer and the destination is the second memory pointer, which is loaded from `per_base`.
- R2: Every unit is one read at the source followed by one write at the destination. `bus_req` stays high and `bus_addr` stays steady until `bus_gnt` is seen. A granted read is always followed by the write of the same unit.
- R3: In peripheral routes, `req` while both enables are high sets `pend`. Starting the unit clears `pend` one cycle later, and each request moves one unit. With no request, nothing moves. The memory-to-memory route runs without requests.
- R4: After each unit, the memory pointer steps by the unit size, upward when `mem_dn`=0 and downward when `mem_dn`=1. The peripheral address never steps. In the memory-to-memory route, the second pointer steps the same way.
- R5: When `wide`=0, a unit is one byte on `bus_wdata[7:0]` and `bus_wdata[15:8]` is zero. When `wide`=1, a unit is 16 bits.
- R6: `cnt_wr` loads both the remaining count and the reload value. Each completed unit decrements `cnt_left`. A count of zero never starts a unit.
- R7: When `circ`=0, the channel stops once the count reaches zero. When `circ`=1, the count and both pointers reload on the final unit and transfers continue.
- R8: `ht_flag` sets when a unit completes and the remaining count equals floor(programmed count / 2). `tc_flag` sets when the remaining count reaches zero.
- R9: `irq` = (`ht_flag` and `ht_ie`) or (`tc_flag` and `tc_ie`).
- R10: `clr_ht` and `clr_tc` each clear only their own flag. A flag being set in the same cycle takes priority over the clear.
- R11: Units start only when both `glb_en` and `ch_en` are high. While the channel is idle and `ch_en` is low, the pointers follow the base inputs.
- R12: If `ch_en` drops while a unit is in flight, that unit finishes, no further unit starts, and `tc_flag` stays clear.
- R13: `busy` is high from the read phase to the end of the write phase of each unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable for the engine |
| ch_en | input | 1 | Channel enable |
| dir | input | 2 | Route select |
| circ | input | 1 | Circular reload mode |
| mem_dn | input | 1 | Memory pointer counts downward |
| wide | input | 1 | Two-byte units |
| ht_ie | input | 1 | Half-way interrupt enable |
| tc_ie | input | 1 | Completion interrupt enable |
| cnt_wr | input | 1 | Load unit count |
| cnt_wdata | input | CW | Unit count to load |
| mem0_base | input | AW | Memory base address |
| per_base | input | AW | Peripheral address, or second memory base |
| clr_ht | input | 1 | Clear half-way flag |
| clr_tc | input | 1 | Clear completion flag |
| req | input | 1 | Peripheral transfer request |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Access address |
| bus_wdata | output | 16 | Write data |
| bus_gnt | input | 1 | Access granted and completed this cycle |
| bus_rdata | input | 16 | Read data, valid with grant |
| cnt_left | output | CW | Remaining units |
| pend | output | 1 | Request outstanding |
| busy | output | 1 | Unit in progress |
| ht_flag | output | 1 | Half-way flag |
| tc_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt |

## Verification
The bench sweeps memory-to-memory copies over both unit sizes, both step directions and every count from 1 to 6. For each run it checks every destination byte against the source pattern and records the count value when the half-way flag rises. A design with an off-by-one in the half-way test shows the wrong count at that point, and a wrong pointer step scrambles or overruns the destination. The bench also stalls the grant to catch an address that drifts or a write that is skipped. It drops the enable mid-unit and expects one unit moved with no completion. It lets a circular run wrap and expects the count reloaded and no bytes written past the buffer.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glb_en,
  input  logic          ch_en,
  input  logic [1:0]    dir,
  input  logic          circ,
  input  logic          mem_dn,
  input  logic          wide,
  input  logic          ht_ie,
  input  logic          tc_ie,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic [AW-1:0] mem0_base,
  input  logic [AW-1:0] per_base,
  input  logic          clr_ht,
  input  logic          clr_tc,
  input  logic          req,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  input  logic          bus_gnt,
  input  logic [15:0]   bus_rdata,
  output logic [CW-1:0] cnt_left,
  output logic          pend,
  output logic          busy,
  output logic          ht_flag,
  output logic          tc_flag,
  output logic          irq
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic [CW-1:0] cnt, cnt_init;
  logic [AW-1:0] mptr, m1ptr;
  logic [15:0]   data;

  wire          run    = glb_en & ch_en;
  wire          m2m    = dir[1];
  wire          go     = run && (cnt != '0) && (m2m || pend);
  wire [AW-1:0] step   = wide ? AW'(2) : AW'(1);
  wire [AW-1:0] src    = (dir == 2'd0) ? per_base : mptr;
  wire [AW-1:0] dst    = (dir == 2'd0) ? mptr : (dir == 2'd1) ? per_base : m1ptr;
  wire          done   = (st == S_WR) && bus_gnt;
  wire [CW-1:0] cnt_nx = cnt - CW'(1);
  wire          last   = done && (cnt_nx == '0);

  assign bus_req   = (st != S_IDLE);
  assign bus_we    = (st == S_WR);
  assign bus_addr  = (st == S_WR) ? dst : src;
  assign bus_wdata = wide ? data : {8'h00, data[7:0]};
  assign busy      = (st != S_IDLE);
  assign cnt_left  = cnt;
  assign irq       = (ht_flag & ht_ie) | (tc_flag & tc_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      data <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) st <= S_RD;
        S_RD:   if (bus_gnt) begin data <= bus_rdata; st <= S_WR; end
        S_WR:   if (bus_gnt) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else if (!run || m2m) pend <= 1'b0;
    else if (req) pend <= 1'b1;
    else if (st == S_IDLE && go) pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mptr <= '0;
      m1ptr <= '0;
    end else if (st == S_IDLE && !ch_en) begin
      mptr <= mem0_base;
      m1ptr <= per_base;
    end else if (done) begin
      if (last && circ) begin
        mptr <= mem0_base;
        m1ptr <= per_base;
      end else begin
        mptr <= mem_dn ? mptr - step : mptr + step;
        if (m2m) m1ptr <= mem_dn ? m1ptr - step : m1ptr + step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      cnt_init <= '0;
    end else if (cnt_wr) begin
      cnt <= cnt_wdata;
      cnt_init <= cnt_wdata;
    end else if (done) begin
      cnt <= (last && circ) ? cnt_init : cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ht_flag <= 1'b0;
      tc_flag <= 1'b0;
    end else begin
      if (done && cnt_nx == (cnt_init >> 1)) ht_flag <= 1'b1;
      else if (clr_ht) ht_flag <= 1'b0;
      if (last) tc_flag <= 1'b1;
      else if (clr_tc) tc_flag <= 1'b0;
    end
  end

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_gnt) |=> (bus_req && bus_we)) else $error("AST_RD_THEN_WR"); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !cnt_wr && $stable(per_base)) |=> (bus_req && $stable(bus_addr))) else $error("AST_ADDR_HOLD"); // R2
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(glb_en && ch_en)) |=> !busy) else $error("AST_NO_START_DISABLED"); // R11
  AST_NORMAL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cnt_left == '0) |=> !busy) else $error("AST_NORMAL_STOP"); // R6
  AST_TC_ON_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> $past(bus_we && bus_gnt)) else $error("AST_TC_ON_UNIT"); // R8
  AST_CIRC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (circ && done && cnt == CW'(1) && !cnt_wr) |=> (cnt_left == cnt_init)) else $error("AST_CIRC_RELOAD"); // R7
endmodule

// File: tb/sim_dma_chan_engine.sv
module sim_dma_chan_engine;
  logic clk = 0, rst_n = 0;
  logic glb_en = 0, ch_en = 0, circ = 0, mem_dn = 0, wide = 0, ht_ie = 0, tc_ie = 0;
  logic [1:0] dir = 0;
  logic cnt_wr = 0, clr_ht = 0, clr_tc = 0, req = 0, gnt_on = 1;
  logic [7:0] cnt_wdata = 0;
  logic [15:0] mem0_base = 0, per_base = 0;
  logic bus_req, bus_we, pend, busy, ht_flag, tc_flag, irq;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic [7:0] cnt_left;
  logic [7:0] mem [256];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_chan_engine u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ch_en(ch_en), .dir(dir), .circ(circ),
    .mem_dn(mem_dn), .wide(wide), .ht_ie(ht_ie), .tc_ie(tc_ie), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .mem0_base(mem0_base), .per_base(per_base), .clr_ht(clr_ht),
    .clr_tc(clr_tc), .req(req), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(gnt_on), .bus_rdata(bus_rdata), .cnt_left(cnt_left),
    .pend(pend), .busy(busy), .ht_flag(ht_flag), .tc_flag(tc_flag), .irq(irq));

  assign bus_rdata = {mem[bus_addr[7:0] + 8'd1], mem[bus_addr[7:0]]};
  always @(posedge clk)
    if (bus_req && bus_we && gnt_on) begin
      mem[bus_addr[7:0]] <= bus_wdata[7:0];
      if (wide) mem[bus_addr[7:0] + 8'd1] <= bus_wdata[15:8];
    end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
  endtask

  task automatic cfg(input int d, input int c, input int dn, input int w,
                     input int m0, input int p, input int n);
    @(negedge clk);
    ch_en = 0; dir = 2'(d); circ = c[0]; mem_dn = dn[0]; wide = w[0];
    mem0_base = 16'(m0); per_base = 16'(p); cnt_wr = 1; cnt_wdata = 8'(n);
    @(negedge clk);
    cnt_wr = 0; clr_ht = 1; clr_tc = 1;
    @(negedge clk);
    clr_ht = 0; clr_tc = 0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1;
    @(negedge clk); req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    fill();
    repeat (3) @(negedge clk);
    chk("R6 reset count", cnt_left, 0);
    chk("R13 reset busy", busy, 0);
    chk("R8 reset flags", {ht_flag, tc_flag}, 0);
    chk("R2 reset bus_req", bus_req, 0);
    rst_n = 1;
    glb_en = 1;

    // R1 R4 R5 R7 R8 sweep of memory-to-memory copies
    for (int w = 0; w < 2; w++)
      for (int dn = 0; dn < 2; dn++)
        for (int n = 1; n <= 6; n++) begin
          int m0, m1, sz, ht_at, bad, cyc;
          bit ht_seen;
          sz = w ? 2 : 1;
          m0 = dn ? 8'h3E : 8'h20;
          m1 = dn ? 8'hBE : 8'h80;
          fill();
          cfg(2, 0, dn, w, m0, m1, n);
          ch_en = 1;
          ht_seen = 0; ht_at = -1; cyc = 0;
          while (!tc_flag && cyc < 200) begin
            @(negedge clk); cyc++;
            if (ht_flag && !ht_seen) begin ht_seen = 1; ht_at = cnt_left; end
          end
          chk("R8 tc set", tc_flag, 1);
          chk("R8 half-way count", ht_at, n / 2);
          chk("R6 count at end", cnt_left, 0);
          chk("R9 irq masked", irq, 0);
          @(negedge clk); @(negedge clk);
          chk("R7 normal stop", busy, 0);
          bad = 0;
          for (int k = 0; k < n; k++)
            for (int b = 0; b < sz; b++) begin
              int s, t;
              s = (dn ? m0 - k * sz : m0 + k * sz) + b;
              t = (dn ? m1 - k * sz : m1 + k * sz) + b;
              if (mem[t & 255] != (8'(s) ^ 8'h5A)) bad++;
            end
          chk("R4 R1 copied data", bad, 0);
          begin
            int o;
            o = dn ? m1 - n * sz : m1 + n * sz;
            chk("R4 no overrun", mem[o & 255], 8'(o) ^ 8'h5A);
          end
        end

    // R9 R10 interrupt masking and flag clears (flags set from last run)
    @(negedge clk); ht_ie = 1; tc_ie = 0;
    #1 chk("R9 irq from ht", irq, 1);
    @(negedge clk); clr_ht = 1;
    @(negedge clk); clr_ht = 0;
    chk("R10 ht cleared", ht_flag, 0);
    chk("R10 tc kept", tc_flag, 1);
    chk("R9 irq after ht clear", irq, 0);
    tc_ie = 1;
    #1 chk("R9 irq from tc", irq, 1);
    @(negedge clk); clr_tc = 1;
    @(negedge clk); clr_tc = 0;
    chk("R10 tc cleared", tc_flag, 0);
    ht_ie = 0; tc_ie = 0;

    // R3 R2 R5 peripheral to memory, byte units
    fill();
    cfg(0, 0, 0, 0, 8'h40, 8'hF0, 3);
    ch_en = 1;
    repeat (10) @(negedge clk);
    chk("R3 no request no move", cnt_left, 3);
    gnt_on = 0;
    mem[8'hF0] = 8'hC0;
    pulse_req();
    chk("R3 pend set", pend, 1);
    chk("R13 not yet busy", busy, 0);
    @(negedge clk);
    chk("R3 pend cleared on start", pend, 0);
    chk("R13 busy in read", busy, 1);
    chk("R1 read at peripheral", bus_addr, 16'hF0);
    repeat (3) @(negedge clk);
    chk("R2 address held in stall", bus_addr, 16'hF0);
    chk("R2 request held in stall", {bus_req, bus_we}, 2'b10);
    gnt_on = 1;
    @(negedge clk);
    chk("R2 write follows read", bus_we, 1);
    chk("R1 write at memory", bus_addr, 16'h40);
    chk("R5 byte upper zero", bus_wdata[15:8], 0);
    @(negedge clk);
    chk("R6 decrement", cnt_left, 2);
    chk("R1 p2m data", mem[8'h40], 8'hC0);
    for (int k = 1; k < 3; k++) begin
      mem[8'hF0] = 8'(8'hC0 + k);
      pulse_req();
      repeat (5) @(negedge clk);
      chk("R3 one unit per request", cnt_left, 3 - k - 1);
      chk("R4 p2m data", mem[(8'h40 + k) & 255], 8'hC0 + k);
    end
    chk("R8 p2m tc", tc_flag, 1);
    pulse_req();
    repeat (5) @(negedge clk);
    chk("R6 zero count never starts", cnt_left, 0);
    chk("R4 no extra write", mem[8'h43], 8'h43 ^ 8'h5A);

    // R1 R4 R5 memory to peripheral, 16-bit downward
    fill();
    cfg(1, 0, 1, 1, 8'h3E, 8'hF2, 2);
    ch_en = 1;
    for (int k = 0; k < 2; k++) begin
      int s;
      s = 8'h3E - 2 * k;
      pulse_req();
      repeat (5) @(negedge clk);
      chk("R5 m2p word", {mem[8'hF3], mem[8'hF2]}, {8'(s + 1) ^ 8'h5A, 8'(s) ^ 8'h5A});
    end
    chk("R6 m2p done", cnt_left, 0);

    // R7 circular reload
    fill();
    cfg(2, 1, 0, 0, 8'h20, 8'h80, 3);
    ch_en = 1;
    begin
      int cyc;
      cyc = 0;
      while (!tc_flag && cyc < 100) begin @(negedge clk); cyc++; end
    end
    chk("R7 count reloaded", cnt_left, 3);
    repeat (7) @(negedge clk);
    ch_en = 0;
    repeat (8) @(negedge clk);
    chk("R12 circular stops when disabled", busy, 0);
    chk("R7 pointer reloaded", mem[8'h83], 8'h83 ^ 8'h5A);
    chk("R7 circular data", mem[8'h82], 8'h22 ^ 8'h5A);

    // R12 abort mid-unit
    fill();
    cfg(2, 0, 0, 0, 8'h20, 8'h80, 10);
    gnt_on = 0;
    ch_en = 1;
    @(negedge clk);
    chk("R13 busy on start", busy, 1);
    ch_en = 0; gnt_on = 1;
    repeat (6) @(negedge clk);
    chk("R12 one unit moved", cnt_left, 9);
    chk("R12 no tc on abort", tc_flag, 0);
    chk("R12 idle after abort", busy, 0);
    chk("R12 unit finished", mem[8'h80], 8'h20 ^ 8'h5A);

    // R11 global enable gates the channel
    cfg(2, 0, 0, 0, 8'h20, 8'h80, 4);
    glb_en = 0; ch_en = 1;
    repeat (10) @(negedge clk);
    chk("R11 global off no move", cnt_left, 4);
    chk("R11 global off idle", busy, 0);
    glb_en = 1;
    repeat (20) @(negedge clk);
    chk("R11 runs once enabled", cnt_left, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule